// File: doc/BRIEF.md
# Recoverable error status collector

This block gathers recoverable error events from a random number generator's control and command paths into a sticky status register and raises a recoverable alert level whenever any status bit is set. It watches for these events:
- invalid encodings in three multi-bit boolean control fields;
- a seeding command whose flag field is not a valid boolean encoding;
- an illegal command code;
- a random output word that repeats the word accepted just before it.

The repeat detector holds the last word accepted on the output handshake. It compares each new accepted word against that stored word. The first word accepted after reset is never compared.

Software clears status bits through a register write port. A bit written as zero is cleared and a bit written as one is kept. A new event that occurs in the same cycle as a clear keeps its bit set.

Top module: `rcv_err_collector`

## Requirements
- R1: After reset `sts_o` is zero and `alert_o` is low. `alert_o` is high in exactly the cycles in which `sts_o` is non-zero.
- R2: A multi-bit boolean is valid only as 4'h6 (true) or 4'h9 (false). Any other value on `ctl_f0_i`, `ctl_f1_i` or `ctl_f2_i` sets status bit 0, 1 or 2 respectively.
- R3: Command codes 1 (instantiate) and 2 (reseed) carry a flag field. When `cmd_valid_i` is high with either code and `cmd_flag_i` is neither 4'h6 nor 4'h9, status bit 3 sets. The flag has no effect for any other code.
- R4: When `cmd_valid_i` is high with `cmd_code_i` equal to 0 or to any value from 6 to 15, status bit 4 sets. Codes 1 to 5 leave bit 4 alone. `cmd_code_i` has no effect while `cmd_valid_i` is low.
- R5: On an accepted word (`word_valid_i` and `word_ready_i` both high), status bit 5 sets if `word_i` equals the previously accepted word. A word that is offered but not accepted neither updates the stored word nor is compared.
- R6: The first word accepted after reset never sets status bit 5.
- R7: When `sts_we_i` is high, each status bit whose `sts_wdata_i` bit is 0 is cleared and each bit whose write bit is 1 is kept. Writing all zeros clears every bit.
- R8: Status bits are sticky. A set bit stays set after its event goes away, until software clears it.
- R9: An event in the same cycle as a clear write leaves its status bit set.
- R10: Every event becomes visible on `sts_o` on the clock edge at the end of the cycle in which it occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ctl_f0_i | input | 4 | Control field 0, multi-bit boolean |
| ctl_f1_i | input | 4 | Control field 1, multi-bit boolean |
| ctl_f2_i | input | 4 | Control field 2, multi-bit boolean |
| cmd_valid_i | input | 1 | Command present this cycle |
| cmd_code_i | input | 4 | Command code |
| cmd_flag_i | input | 4 | Command flag, multi-bit boolean |
| word_valid_i | input | 1 | Output word valid |
| word_ready_i | input | 1 | Output word accepted by consumer |
| word_i | input | WORD_W | Random output word |
| sts_we_i | input | 1 | Status register write strobe |
| sts_wdata_i | input | 6 | Status write data, a zero bit clears |
| sts_o | output | 6 | Sticky status bits |
| alert_o | output | 1 | Recoverable alert level |

## Verification
Two functions can fall in the same cycle: an event that sets a status bit and a software write that clears the bits. To provoke this, the bench holds an invalid value on a control field while it writes zeros to the status register. It then checks that the bit is still set after that edge. A second case pairs a partial clear with a new event on another bit, and the bench checks that only the bits written as zero, and not hit by an event, drop.

// File: rtl/rcv_err_pkg.sv
package rcv_err_pkg;
  localparam int unsigned BOOL_W     = 4;
  localparam int unsigned CODE_W     = 4;
  localparam int unsigned NUM_FLD    = 3;
  localparam int unsigned STS_W      = NUM_FLD + 3;
  localparam int unsigned IDX_FLAG   = NUM_FLD;
  localparam int unsigned IDX_CODE   = NUM_FLD + 1;
  localparam int unsigned IDX_REPEAT = NUM_FLD + 2;

  localparam logic [BOOL_W-1:0] BOOL_TRUE  = 4'h6;
  localparam logic [BOOL_W-1:0] BOOL_FALSE = 4'h9;

  localparam logic [CODE_W-1:0] CODE_INST   = 4'd1;
  localparam logic [CODE_W-1:0] CODE_RESEED = 4'd2;
  localparam logic [CODE_W-1:0] CODE_LAST   = 4'd5;

  function automatic logic bool_invalid(logic [BOOL_W-1:0] v);
    return (v != BOOL_TRUE) && (v != BOOL_FALSE);
  endfunction
endpackage

// File: rtl/rcv_bool_chk.sv
module rcv_bool_chk
  import rcv_err_pkg::*;
(
  input  logic [BOOL_W-1:0] fld_i,
  output logic              bad_o
);
  assign bad_o = bool_invalid(fld_i);
endmodule

// File: rtl/rcv_cmd_chk.sv
module rcv_cmd_chk
  import rcv_err_pkg::*;
(
  input  logic              cmd_valid_i,
  input  logic [CODE_W-1:0] cmd_code_i,
  input  logic [BOOL_W-1:0] cmd_flag_i,
  output logic              illegal_o,
  output logic              bad_flag_o
);
  logic code_legal, seeding;

  assign code_legal = (cmd_code_i != '0) && (cmd_code_i <= CODE_LAST);
  assign seeding    = (cmd_code_i == CODE_INST) || (cmd_code_i == CODE_RESEED);

  assign illegal_o  = cmd_valid_i && !code_legal;
  assign bad_flag_o = cmd_valid_i && seeding && bool_invalid(cmd_flag_i);
endmodule

// File: rtl/rcv_repeat_det.sv
module rcv_repeat_det #(
  parameter int unsigned WORD_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic              ready_i,
  input  logic [WORD_W-1:0] word_i,
  output logic              rep_o
);
  logic              take;
  logic              have_ref_q;
  logic [WORD_W-1:0] ref_q;

  assign take  = valid_i && ready_i;
  assign rep_o = take && have_ref_q && (word_i == ref_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      have_ref_q <= 1'b0;
      ref_q      <= '0;
    end else if (take) begin
      have_ref_q <= 1'b1;
      ref_q      <= word_i;
    end
  end

  AST_REF_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !take |=> $stable(ref_q)); // R5

  AST_FIRST_FREE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take && !have_ref_q) |-> !rep_o); // R6
endmodule

// File: rtl/rcv_err_collector.sv
module rcv_err_collector
  import rcv_err_pkg::*;
#(
  parameter int unsigned WORD_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [BOOL_W-1:0] ctl_f0_i,
  input  logic [BOOL_W-1:0] ctl_f1_i,
  input  logic [BOOL_W-1:0] ctl_f2_i,
  input  logic              cmd_valid_i,
  input  logic [CODE_W-1:0] cmd_code_i,
  input  logic [BOOL_W-1:0] cmd_flag_i,
  input  logic              word_valid_i,
  input  logic              word_ready_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic              sts_we_i,
  input  logic [STS_W-1:0]  sts_wdata_i,
  output logic [STS_W-1:0]  sts_o,
  output logic              alert_o
);
  logic [NUM_FLD-1:0][BOOL_W-1:0] fld;
  logic [STS_W-1:0] evt, sts_d, sts_q;

  assign fld = {ctl_f2_i, ctl_f1_i, ctl_f0_i};

  for (genvar i = 0; i < NUM_FLD; i++) begin : g_fld
    rcv_bool_chk u_chk (
      .fld_i (fld[i]),
      .bad_o (evt[i])
    );
  end

  rcv_cmd_chk u_cmd (
    .cmd_valid_i (cmd_valid_i),
    .cmd_code_i  (cmd_code_i),
    .cmd_flag_i  (cmd_flag_i),
    .illegal_o   (evt[IDX_CODE]),
    .bad_flag_o  (evt[IDX_FLAG])
  );

  rcv_repeat_det #(.WORD_W(WORD_W)) u_rep (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (word_valid_i),
    .ready_i (word_ready_i),
    .word_i  (word_i),
    .rep_o   (evt[IDX_REPEAT])
  );

  // zero-to-clear, events take priority
  always_comb begin
    sts_d = sts_q;
    if (sts_we_i) sts_d = sts_q & sts_wdata_i;
    sts_d = sts_d | evt;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sts_q <= '0;
    else         sts_q <= sts_d;
  end

  assign sts_o   = sts_q;
  assign alert_o = |sts_q;

  AST_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sts_we_i |=> ((sts_o & $past(sts_o)) == $past(sts_o))); // R8

  AST_CLR_ALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sts_we_i && sts_wdata_i == '0 && evt == '0) |=> (sts_o == '0)); // R7

  AST_EVT_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt != '0) |=> ((sts_o & $past(evt)) == $past(evt))); // R9

  AST_ALERT_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(alert_o) |-> ($past(evt) != '0)); // R1
endmodule

// File: tb/rcv_err_collector_tb.sv
`timescale 1ns/1ps
module rcv_err_collector_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [3:0]  ctl_f0_i = 4'h6, ctl_f1_i = 4'h9, ctl_f2_i = 4'h6;
  logic        cmd_valid_i = 1'b0;
  logic [3:0]  cmd_code_i = 4'd1, cmd_flag_i = 4'h6;
  logic        word_valid_i = 1'b0, word_ready_i = 1'b0;
  logic [31:0] word_i = '0;
  logic        sts_we_i = 1'b0;
  logic [5:0]  sts_wdata_i = '0;
  logic [5:0]  sts_o;
  logic        alert_o;
  int          n_run = 0, n_fail = 0;
  bit          done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  rcv_err_collector u_dut (.*);

  // {f0, f1, f2, cmd_valid, code, flag, expected status}
  localparam logic [26:0] VEC [10] = '{
    {4'h3, 4'h9, 4'h6, 1'b0, 4'd1, 4'h6, 6'b000001},
    {4'h6, 4'h0, 4'h6, 1'b0, 4'd1, 4'h6, 6'b000010},
    {4'h9, 4'h9, 4'hF, 1'b0, 4'd1, 4'h6, 6'b000100},
    {4'h6, 4'h9, 4'h6, 1'b1, 4'd1, 4'h6, 6'b000000},
    {4'h6, 4'h9, 4'h6, 1'b1, 4'd2, 4'h5, 6'b001000},
    {4'h6, 4'h9, 4'h6, 1'b1, 4'd0, 4'h6, 6'b010000},
    {4'h6, 4'h9, 4'h6, 1'b1, 4'd7, 4'h0, 6'b010000},
    {4'h6, 4'h9, 4'h6, 1'b1, 4'd3, 4'h0, 6'b000000},
    {4'h6, 4'h9, 4'h6, 1'b1, 4'd5, 4'h0, 6'b000000},
    {4'h9, 4'h6, 4'h9, 1'b1, 4'd1, 4'h9, 6'b000000}
  };

  task automatic chk(input string req, input logic [5:0] exp);
    n_run++;
    if (sts_o !== exp || alert_o !== (|exp)) begin
      n_fail++;
      $display("FAIL %s: sts=%b alert=%b expected sts=%b alert=%b",
               req, sts_o, alert_o, exp, |exp);
    end
  endtask

  task automatic idle();
    ctl_f0_i = 4'h6; ctl_f1_i = 4'h9; ctl_f2_i = 4'h6;
    cmd_valid_i = 1'b0; word_valid_i = 1'b0; word_ready_i = 1'b0;
    sts_we_i = 1'b0;
  endtask

  task automatic step();
    @(posedge clk_i); @(negedge clk_i);
  endtask

  task automatic clear_all();
    idle(); sts_we_i = 1'b1; sts_wdata_i = '0;
    step(); sts_we_i = 1'b0;
  endtask

  task automatic push(input logic [31:0] w, input logic rdy);
    word_i = w; word_valid_i = 1'b1; word_ready_i = rdy;
    step(); word_valid_i = 1'b0; word_ready_i = 1'b0;
  endtask

  initial begin
    #1000000;
    if (!done) begin
      n_fail++; n_run++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk("R1 reset", 6'b0);
    rst_ni = 1'b1;
    step();
    chk("R1 idle after reset", 6'b0);

    // repeat detector
    push(32'hA5A5_0001, 1'b1);
    chk("R6 first accepted word", 6'b0);
    push(32'hA5A5_0001, 1'b1);
    chk("R5 repeated word", 6'b100000);
    clear_all();
    chk("R7 clear after repeat", 6'b0);
    push(32'h1234_5678, 1'b0);
    push(32'hA5A5_0001, 1'b1);
    chk("R5 unaccepted word leaves reference", 6'b100000);
    clear_all();
    push(32'h1234_5678, 1'b1);
    chk("R5 distinct word", 6'b0);

    // table walk
    foreach (VEC[i]) begin
      ctl_f0_i = VEC[i][26:23]; ctl_f1_i = VEC[i][22:19]; ctl_f2_i = VEC[i][18:15];
      cmd_valid_i = VEC[i][14]; cmd_code_i = VEC[i][13:10]; cmd_flag_i = VEC[i][9:6];
      step();
      idle();
      chk($sformatf("R2 R3 R4 R10 vector %0d", i), VEC[i][5:0]);
      clear_all();
    end

    // code ignored while not valid
    cmd_code_i = 4'd0; step();
    chk("R4 code without valid", 6'b0);

    // sticky
    ctl_f1_i = 4'h1; step(); idle();
    step(); step();
    chk("R8 sticky after cause removed", 6'b000010);

    // partial clear with simultaneous event on another bit
    cmd_valid_i = 1'b1; cmd_code_i = 4'd9; step(); idle();
    chk("R4 second bit", 6'b010010);
    sts_we_i = 1'b1; sts_wdata_i = 6'b000010; ctl_f2_i = 4'h0;
    step(); idle();
    chk("R7 R9 partial clear with event", 6'b000110);

    // event beats full clear
    sts_we_i = 1'b1; sts_wdata_i = '0; ctl_f0_i = 4'hC;
    step(); idle();
    chk("R9 event wins over clear", 6'b000001);
    clear_all();
    chk("R7 R1 all cleared", 6'b0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule